// File: doc/BRIEF.md
# Opcode Fetch Bus-Cycle Sequencer

This block drives the bus control signals for an instruction-fetch machine cycle of an 8-bit processor with a 16-bit address bus. Each fetch has four clock states, T1 to T4. The first two states read the opcode from memory at the program counter address. The last two states are used for a dynamic-memory refresh at an address supplied by a refresh counter.

The strobes change on both halves of the clock. The address and the state-derived outputs (fetch marker, refresh strobe, opcode-valid) change on the rising edge. Memory request and read go active on a falling edge, half a clock after the address, so the address has settled before the memory is enabled. The opcode is captured on the rising edge that starts T3. That same edge releases read and memory request, so the data is held before read goes inactive.

A request sampled while idle, or in T4, starts a T1 on the next rising edge. Back-to-back fetches therefore run without a gap.

Top module: `fetch_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, mreq_n, rd_n, m1_n and rfsh_n are all high (inactive) and opc_valid is 0.
- R2: A fetch_req seen high on a rising edge while idle starts T1 on that edge. During T1 and T2 the address bus carries the pc_in value sampled on that edge, and m1_n is low.
- R3: mreq_n and rd_n stay high during the first half of T1. They go low together on the falling edge in T1 and stay low through T2. rd_n is never low while mreq_n is high.
- R4: On the rising edge that begins T3, mreq_n, rd_n and m1_n all return high.
- R5: The value on data_in at the rising edge that begins T3 is stored in opcode. opc_valid is high for exactly the T3 clock. opcode keeps its value until the next fetch captures a new one.
- R6: During T3 and T4 the address bus carries the rfsh_in value sampled at the start of T3, rfsh_n is low, and rd_n stays high.
- R7: During refresh, mreq_n goes low on the falling edge in T3 and returns high on the falling edge in T4.
- R8: A fetch_req seen high on the rising edge that ends T4 starts the next T1 at once. mreq_n and rd_n are high in the first half of that T1.
- R9: fetch_req is ignored from T1 to T3. With fetch_req low at the end of T4 the block goes idle: all strobes are high and the address bus holds the last refresh address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_req | input | 1 | Request to start a fetch cycle |
| pc_in | input | 16 | Program counter value to fetch from |
| rfsh_in | input | 16 | Refresh address for T3/T4 |
| data_in | input | 8 | External data bus |
| addr_out | output | 16 | Address bus |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read strobe, active low |
| m1_n | output | 1 | Fetch-cycle marker, active low |
| rfsh_n | output | 1 | Refresh strobe, active low |
| opcode | output | 8 | Captured opcode |
| opc_valid | output | 1 | One-clock pulse when opcode is new |

## Verification
The rising-edge state register and the falling-edge copy of it jointly form every strobe. A state that is wrong in either one shows up at the ports within half a clock: mreq_n either opens in the first half of T1 or misses its refresh window. If the state sequence skips or repeats a state, m1_n and rfsh_n overlap or gap, and the opcode scoreboard sees a missing or extra valid pulse on the next fetch. A wrong capture edge appears as the next data value in opcode at T3.

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] rfsh_in,
  input  logic [DW-1:0] data_in,
  output logic [AW-1:0] addr_out,
  output logic          mreq_n,
  output logic          rd_n,
  output logic          m1_n,
  output logic          rfsh_n,
  output logic [DW-1:0] opcode,
  output logic          opc_valid
);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_T4} st_t;

  st_t st, st_nx, fst;

  always_comb begin
    case (st)
      S_IDLE:  st_nx = fetch_req ? S_T1 : S_IDLE;
      S_T1:    st_nx = S_T2;
      S_T2:    st_nx = S_T3;
      S_T3:    st_nx = S_T4;
      S_T4:    st_nx = fetch_req ? S_T1 : S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_out <= '0;
      opcode   <= '0;
    end else begin
      st <= st_nx;
      if (st_nx == S_T1)
        addr_out <= pc_in;
      else if (st == S_T2)
        addr_out <= rfsh_in;
      if (st == S_T2)
        opcode <= data_in;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fst <= S_IDLE;
    else        fst <= st;
  end

  logic in_fetch, rd_on;
  assign in_fetch  = (st == S_T1) || (st == S_T2);
  assign rd_on     = in_fetch && ((fst == S_T1) || (fst == S_T2));
  assign rd_n      = !rd_on;
  assign mreq_n    = !(rd_on || (fst == S_T3));
  assign m1_n      = !in_fetch;
  assign rfsh_n    = !((st == S_T3) || (st == S_T4));
  assign opc_valid = (st == S_T3);

  a_r3_rd_inside_mreq: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !mreq_n);
  a_r3_read_open_end_t1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T1) |-> (!rd_n && !mreq_n));
  a_r6_refresh_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> (rd_n && m1_n));
  a_r7_refresh_req_end_t3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T3) |-> !mreq_n);
  a_r7_refresh_req_off_t4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T4) |-> mreq_n);
  a_r5_valid_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    opc_valid |=> !opc_valid);
  a_r2_addr_held_t2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T2) |-> $stable(addr_out));

endmodule

// File: tb/fetch_seq_tb.sv
module fetch_seq_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        fetch_req = 0;
  logic [15:0] pc_in = '0, rfsh_in = '0, addr_out;
  logic [7:0]  data_in = '0, opcode;
  logic        mreq_n, rd_n, m1_n, rfsh_n, opc_valid;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .pc_in(pc_in),
    .rfsh_in(rfsh_in), .data_in(data_in), .addr_out(addr_out),
    .mreq_n(mreq_n), .rd_n(rd_n), .m1_n(m1_n), .rfsh_n(rfsh_n),
    .opcode(opcode), .opc_valid(opc_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && opc_valid) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected valid", {24'h0, opcode}, 32'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(opcode == e, "R5 scoreboard opcode", {24'h0, opcode}, {24'h0, e});
      end
    end
  end

  task automatic fetch(input logic [15:0] pc, input logic [7:0] op, input logic [15:0] rf, input bit hold);
    fetch_req = 1; pc_in = pc;
    exp_q.push_back(op);
    @(posedge clk); #5;
    chk(addr_out == pc, "R2 addr", {16'h0, addr_out}, {16'h0, pc});
    chk(!m1_n, "R2 m1_n", {31'h0, m1_n}, 0);
    chk(mreq_n && rd_n, "R3/R8 early T1 idle", {30'h0, mreq_n, rd_n}, 32'h3);
    if (!hold) fetch_req = 0;
    data_in = op;
    #10;
    chk(!mreq_n && !rd_n, "R3 late T1", {30'h0, mreq_n, rd_n}, 0);
    @(posedge clk); #5;
    chk(!mreq_n && !rd_n && !m1_n, "R3 T2", {29'h0, mreq_n, rd_n, m1_n}, 0);
    rfsh_in = rf; pc_in = ~pc;
    #10;
    chk(addr_out == pc, "R2 addr T2", {16'h0, addr_out}, {16'h0, pc});
    @(posedge clk); #5;
    chk(mreq_n && rd_n && m1_n, "R4 T3 release", {29'h0, mreq_n, rd_n, m1_n}, 32'h7);
    chk(opc_valid && opcode == op, "R5 capture", {23'h0, opc_valid, opcode}, {23'h1, op});
    chk(addr_out == rf && !rfsh_n, "R6 T3", {15'h0, rfsh_n, addr_out}, {16'h0, rf});
    data_in = ~op; fetch_req = 0;
    #10;
    chk(!mreq_n && rd_n, "R7 mid T3", {30'h0, mreq_n, rd_n}, 32'h1);
    @(posedge clk); #5;
    chk(!mreq_n && !rfsh_n && rd_n, "R7/R6 T4", {29'h0, mreq_n, rfsh_n, rd_n}, 32'h1);
    chk(!opc_valid && opcode == op, "R5 hold", {23'h0, opc_valid, opcode}, {23'h0, op});
    #10;
    chk(mreq_n && !rfsh_n && addr_out == rf, "R7 late T4", {14'h0, mreq_n, rfsh_n, addr_out}, {16'h2, rf});
  endtask

  task automatic idle_chk(input logic [15:0] rf);
    fetch_req = 0;
    @(posedge clk); #5;
    chk(mreq_n && rd_n && m1_n && rfsh_n && !opc_valid, "R9 idle strobes",
        {27'h0, mreq_n, rd_n, m1_n, rfsh_n, opc_valid}, 32'h1E);
    chk(addr_out == rf, "R9 addr hold", {16'h0, addr_out}, {16'h0, rf});
    #10;
    chk(mreq_n && rd_n, "R9 idle late", {30'h0, mreq_n, rd_n}, 32'h3);
  endtask

  initial begin
    #200000;
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #15;
    chk(mreq_n && rd_n && m1_n && rfsh_n && !opc_valid, "R1 in reset",
        {27'h0, mreq_n, rd_n, m1_n, rfsh_n, opc_valid}, 32'h1E);
    @(posedge clk); #5; rst_n = 1;
    @(posedge clk); #5;
    chk(mreq_n && rd_n && m1_n && rfsh_n && !opc_valid, "R1 after reset",
        {27'h0, mreq_n, rd_n, m1_n, rfsh_n, opc_valid}, 32'h1E);
    fetch(16'h1234, 8'hA5, 16'h0040, 0);
    idle_chk(16'h0040);
    fetch(16'hFFFF, 8'h00, 16'h007F, 0);
    for (int i = 0; i < 3; i++)
      fetch(16'h0000 + 16'(i), 8'hFF - 8'(i), 16'h0010 + 16'(i), 0);
    idle_chk(16'h0012);
    fetch(16'h8001, 8'h3C, 16'h0055, 1);
    idle_chk(16'h0055);
    @(posedge clk); #5;
    chk(exp_q.size() == 0, "R5 all opcodes seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule